// File: doc/BRIEF.md
# Per-Byte Receive Parity Generator

This block sits on the receive path after word alignment. For each 32-bit received word it produces one parity bit per byte lane. The word, its data/ordered-set indicator and the four parity bits are registered together, so downstream logic sees a word and its parity in the same cycle.

Odd parity is used throughout. A fold mode makes the top-lane parity also cover the indicator bit, so a checker on the far side also protects the word-type flag. A raw mode turns off parity generation and places four caller-supplied bits, one per lane, on the parity outputs instead. The mode controls are sampled with each accepted word. The indicator itself is produced upstream, and checking is done by the consumer.

Top module: `rx_lane_parity`

## Requirements
- R1: Outside raw mode, par_o[n] for n = 0, 1, 2 is high exactly when data_i[8n+7:8n] of the accepted word holds an even number of ones (odd parity).
- R2: Outside raw mode with fold_mode_i low, par_o[3] is high exactly when data_i[31:24] holds an even number of ones, whatever os_flag_i is.
- R3: Outside raw mode with fold_mode_i high, par_o[3] is high exactly when data_i[31:24] and os_flag_i together hold an even number of ones; bits 2..0 are unaffected by os_flag_i.
- R4: With raw_mode_i high, par_o[n] equals raw_par_i[n] for each lane n, and no parity is computed.
- R5: data_o and os_flag_o equal the data_i and os_flag_i of the accepted word (os_flag high marks an ordered set), and they appear on the same clock edge as its parity, one cycle after acceptance.
- R6: fold_mode_i and raw_mode_i are sampled with each accepted word, so consecutive words may use different modes with no carry-over.
- R7: While word_en_i is low, data_o, os_flag_o and par_o keep their values whatever the other inputs do.
- R8: While rst_ni is low, data_o, os_flag_o and par_o are zero. The reset is applied asynchronously and released synchronously to clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive word clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| word_en_i | input | 1 | Accepts the word on the inputs at this edge |
| data_i | input | 32 | Received word, lane n is bits 8n+7..8n |
| os_flag_i | input | 1 | High for an ordered set, low for data |
| fold_mode_i | input | 1 | Top-lane parity also covers os_flag_i |
| raw_mode_i | input | 1 | Place raw_par_i on the parity outputs |
| raw_par_i | input | 4 | Raw-mode bit for each lane |
| data_o | output | 32 | Registered word |
| os_flag_o | output | 1 | Registered indicator |
| par_o | output | 4 | Registered per-lane parity or raw bits |

## Verification
The bench uses all-zero and all-one words, since a design that computed even parity would invert every bit on these. Walking-one words show whether lane slices are shifted or swapped. The indicator is toggled under both fold settings: a design that ignored the fold would get par_o[3] wrong only on ordered sets, and one that folded into the wrong lane would corrupt a lower bit. The modes change on every word and the enable is dropped while the inputs keep moving. A design that registered the controls one word late, or did not hold its outputs when idle, would then report stale parity.

// File: rtl/rxpar_pkg.sv
package rxpar_pkg;
  parameter int unsigned LANE_W_DEF = 8;
  parameter int unsigned LANES_DEF  = 4;

  // odd parity: one when the count of ones is even
  function automatic logic odd_bit(input logic [LANE_W_DEF:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/rxpar_lane.sv
module rxpar_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic              xtra_en_i,
  input  logic              xtra_i,
  output logic              par_o
);
  logic xtra_bit;

  always_comb begin
    xtra_bit = xtra_en_i & xtra_i;
    par_o    = ~(^{lane_i, xtra_bit});
  end
endmodule

// File: rtl/rxpar_sel.sv
module rxpar_sel #(
  parameter int unsigned LANES = 4
) (
  input  logic             raw_mode_i,
  input  logic [LANES-1:0] calc_i,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] par_o
);
  always_comb begin
    par_o = raw_mode_i ? raw_i : calc_i;
  end
endmodule

// File: rtl/rxpar_regs.sv
module rxpar_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              os_i,
  input  logic [LANES-1:0]  par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              os_o,
  output logic [LANES-1:0]  par_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              os_q, os_d;
  logic [LANES-1:0]  par_q, par_d;

  always_comb begin
    data_d = data_q;
    os_d   = os_q;
    par_d  = par_q;
    if (en_i) begin
      data_d = data_i;
      os_d   = os_i;
      par_d  = par_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      os_q   <= 1'b0;
      par_q  <= '0;
    end else begin
      data_q <= data_d;
      os_q   <= os_d;
      par_q  <= par_d;
    end
  end

  assign data_o = data_q;
  assign os_o   = os_q;
  assign par_o  = par_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(data_q) && $stable(os_q) && $stable(par_q)));
endmodule

// File: rtl/rx_lane_parity.sv
module rx_lane_parity
  import rxpar_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     word_en_i,
  input  logic [LANE_W*LANES-1:0]  data_i,
  input  logic                     os_flag_i,
  input  logic                     fold_mode_i,
  input  logic                     raw_mode_i,
  input  logic [LANES-1:0]         raw_par_i,
  output logic [LANE_W*LANES-1:0]  data_o,
  output logic                     os_flag_o,
  output logic [LANES-1:0]         par_o
);
  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned TOP    = LANES - 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LANES-1:0] calc_par;
  logic [LANES-1:0] sel_par;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic fold_en;
    if (g == TOP) begin : g_top
      assign fold_en = fold_mode_i;
    end else begin : g_low
      assign fold_en = 1'b0;
    end
    rxpar_lane #(.LANE_W(LANE_W)) u_lane (
      .lane_i   (data_i[g*LANE_W +: LANE_W]),
      .xtra_en_i(fold_en),
      .xtra_i   (os_flag_i),
      .par_o    (calc_par[g])
    );
  end

  rxpar_sel #(.LANES(LANES)) u_sel (
    .raw_mode_i(raw_mode_i),
    .calc_i    (calc_par),
    .raw_i     (raw_par_i),
    .par_o     (sel_par)
  );

  rxpar_regs #(.DATA_W(DATA_W), .LANES(LANES)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .en_i  (word_en_i),
    .data_i(data_i),
    .os_i  (os_flag_i),
    .par_i (sel_par),
    .data_o(data_o),
    .os_o  (os_flag_o),
    .par_o (par_o)
  );

  assert_low_lanes_R1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (word_en_i && !raw_mode_i) |=> (^{data_o[LANE_W-1:0], par_o[0]}) == 1'b1);

  assert_top_plain_R2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (word_en_i && !raw_mode_i && !fold_mode_i)
      |=> (^{data_o[DATA_W-1 -: LANE_W], par_o[TOP]}) == 1'b1);

  assert_top_fold_R3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (word_en_i && !raw_mode_i && fold_mode_i)
      |=> (^{data_o[DATA_W-1 -: LANE_W], os_flag_o, par_o[TOP]}) == 1'b1);

  assert_raw_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (word_en_i && raw_mode_i) |=> par_o == $past(raw_par_i));

  assert_data_align_R5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    word_en_i |=> (data_o == $past(data_i) && os_flag_o == $past(os_flag_i)));

  assert_reset_zero_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && !os_flag_o && par_o == '0));
endmodule

// File: tb/test_rx_lane_parity.sv
module test_rx_lane_parity;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] data;
  logic        os;
  logic        fold;
  logic        raw;
  logic [3:0]  rawp;
  logic [31:0] data_o;
  logic        os_o;
  logic [3:0]  par_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rx_lane_parity i_rx_lane_parity (
    .clk_i(clk), .rst_ni(rst_n), .word_en_i(en), .data_i(data),
    .os_flag_i(os), .fold_mode_i(fold), .raw_mode_i(raw), .raw_par_i(rawp),
    .data_o(data_o), .os_flag_o(os_o), .par_o(par_o)
  );

  function automatic logic [3:0] model(input logic [31:0] d, input logic o,
                                       input logic f, input logic r,
                                       input logic [3:0] rp);
    logic [3:0] p;
    if (r) return rp;
    for (int i = 0; i < 4; i++) p[i] = ~(^d[i*8 +: 8]);
    if (f) p[3] = ~(^{d[31:24], o});
    return p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one word at a negedge, check it at the next negedge
  task automatic push(input string tag, input logic [31:0] d, input logic o,
                      input logic f, input logic r, input logic [3:0] rp);
    @(negedge clk);
    en = 1'b1; data = d; os = o; fold = f; raw = r; rawp = rp;
    @(negedge clk);
    chk({tag, " par"}, {28'h0, par_o}, {28'h0, model(d, o, f, r, rp)});
    chk("R5 data", data_o, d);
    chk("R5 os", {31'h0, os_o}, {31'h0, o});
  endtask

  task automatic do_reset();
    en = 1'b0; data = '0; os = 1'b0; fold = 1'b0; raw = 1'b0; rawp = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 reset data", data_o, 32'h0);
    chk("R8 reset par", {28'h0, par_o}, 32'h0);
    chk("R8 reset os", {31'h0, os_o}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_lanes();
    push("R1 zeros", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'h0);
    push("R1 ones", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'h0);
    push("R1 mixed", 32'h0102_0307, 1'b0, 1'b0, 1'b0, 4'h0);
    push("R1 alt", 32'hA5C3_7E81, 1'b0, 1'b0, 1'b0, 4'h0);
    for (int i = 0; i < 32; i++)
      push("R1 walk", 32'h1 << i, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_fold();
    push("R2 os ignored", 32'h0300_0000, 1'b1, 1'b0, 1'b0, 4'h0);
    push("R2 os low", 32'h0100_0000, 1'b0, 1'b0, 1'b0, 4'h0);
    push("R3 fold os1", 32'h0100_0000, 1'b1, 1'b1, 1'b0, 4'h0);
    push("R3 fold os0", 32'h0100_0000, 1'b0, 1'b1, 1'b0, 4'h0);
    push("R3 fold low lanes", 32'h00FF_0100, 1'b1, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_raw();
    push("R4 raw 0", 32'h0000_0000, 1'b0, 1'b0, 1'b1, 4'h0);
    push("R4 raw F", 32'h0000_0000, 1'b1, 1'b1, 1'b1, 4'hF);
    push("R4 raw 5", 32'h1234_5678, 1'b0, 1'b0, 1'b1, 4'h5);
    push("R4 raw A", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_switch();
    push("R6 raw word", 32'h8000_0000, 1'b1, 1'b1, 1'b1, 4'h6);
    push("R6 fold word", 32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'h6);
    push("R6 plain word", 32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'h6);
    push("R6 raw again", 32'h8000_0000, 1'b1, 1'b0, 1'b1, 4'h9);
  endtask

  task automatic t_hold();
    logic [31:0] d0;
    logic [3:0]  p0;
    logic        o0;
    push("R7 load", 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 4'h0);
    d0 = data_o; p0 = par_o; o0 = os_o;
    @(negedge clk);
    en = 1'b0; data = 32'h0F0F_0F0F; os = 1'b0; raw = 1'b1; rawp = ~p0;
    repeat (3) @(negedge clk);
    chk("R7 hold data", data_o, d0);
    chk("R7 hold par", {28'h0, par_o}, {28'h0, p0});
    chk("R7 hold os", {31'h0, os_o}, {31'h0, o0});
  endtask

  initial begin
    rst_n = 1'b1;
    do_reset();
    t_lanes();
    t_fold();
    t_raw();
    t_switch();
    t_hold();
    do_reset();
    push("R1 after reset", 32'h7700_0011, 1'b0, 1'b0, 1'b0, 4'h0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule